// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

The block is a synchronous binary up-counter built from identical 4-bit stages. Each stage can be preset from a data word, can count up by one, or can hold its value. An active-low clear empties it at once, without waiting for a clock edge. Each stage has two count enables. One of them also qualifies the stage's all-ones carry, so each stage's carry can feed the next stage's carry enable. This way the stages form one wide counter that steps as a single binary number on a shared clock, with no rippled clocks.

The top level places a parameterised number of stages in a chain. The clock, the clear, the load and the shared count enable go to every stage. The carry enable enters the lowest stage and passes upward through the stage carries, and the carry of the last stage leaves the block. The clear reaches every stage as soon as it goes low. Its release is retimed through a short synchroniser, so all stages leave reset on the same clock edge.

Top module: `cnt_chain`

## Requirements
- R1: While `clear_n` is low, `q` is all zeros and `carry_out` is low. This takes effect as soon as `clear_n` falls, before any clock edge, and it overrides load and count.
- R2: After `clear_n` rises, the first two rising clock edges (SYNC_STAGES = 2) leave `q` at zero whatever the other inputs are. The third edge is the first one that acts.
- R3: With the clear released and `load_n` low, a rising edge copies `din` into `q`, whatever the two enables are. Load takes priority over count.
- R4: With `load_n` high and both `cnt_en` and `chain_en` high, a rising edge increments `q` by one as a single binary number of NSTAGES*4 bits.
- R5: With `load_n` high and either `cnt_en` or `chain_en` low, a rising edge leaves `q` unchanged.
- R6: Counting from all ones wraps `q` to zero on the next counting edge.
- R7: A stage above the lowest one steps only on an edge where every stage below it holds 15. For example, counting from 0x0F gives 0x10.
- R8: `carry_out` is high exactly when `chain_en` is high and every bit of `q` is one. It is combinational and follows `chain_en` within the cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all stages |
| clear_n | input | 1 | Active-low clear; asserts asynchronously, releases after the synchroniser |
| load_n | input | 1 | Active-low synchronous parallel load |
| cnt_en | input | 1 | Count enable shared by every stage |
| chain_en | input | 1 | Carry enable into the lowest stage; also qualifies `carry_out` |
| din | input | NSTAGES*4 | Parallel load value |
| q | output | NSTAGES*4 | Counter value |
| carry_out | output | 1 | All-ones carry of the last stage |

## Verification
The hardest case to reach from the ports is a carry crossing between stages at the moment it matters. The upper stage must step only on the edge where the lower stage sits at 15, and the top carry must appear only at the full all-ones value. Counting there from reset would take hundreds of cycles, so the stimulus uses the parallel load to place the counter at 0x0F, 0xFE and 0xFF, and then counts across the boundary. The clear release window is also reached directly: the clear drops in the middle of a cycle while a load is pending, and the bench then checks each edge of the synchroniser delay.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  // Per-stage operating mode, resolved by priority: load over count over hold.
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2
  } mode_e;
endpackage

// File: rtl/cnt_clr_sync.sv
module cnt_clr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clear_n,
  output logic clr_sync_n
);
  logic [STAGES-1:0] sh;

  // Asserts at once, releases after STAGES rising edges.
  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n) sh <= '0;
    else          sh <= (sh << 1) | STAGES'(1);
  end

  assign clr_sync_n = sh[STAGES-1];
endmodule

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
  import cnt_pkg::*;
(
  input  logic  load_n,
  input  logic  en_p,
  input  logic  en_t,
  output mode_e mode
);
  always_comb begin
    if (!load_n)          mode = MODE_LOAD;
    else if (en_p && en_t) mode = MODE_COUNT;
    else                  mode = MODE_HOLD;
  end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         en_p,
  input  logic         en_t,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         tc
);
  mode_e mode;

  cnt_mode_dec u_dec (
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .mode   (mode)
  );

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      q <= '0;
    end else begin
      case (mode)
        MODE_LOAD:  q <= d;
        MODE_COUNT: q <= q + 1'b1;
        default:    q <= q;
      endcase
    end
  end

  // Terminal count qualified by the carry-side enable only.
  assign tc = en_t & (&q);
endmodule

// File: rtl/cnt_chain.sv
module cnt_chain #(
  parameter  int NSTAGES     = 2,
  parameter  int STAGE_W     = 4,
  parameter  int SYNC_STAGES = 2,
  localparam int TOTAL_W     = NSTAGES * STAGE_W
) (
  input  logic               clk,
  input  logic               clear_n,
  input  logic               load_n,
  input  logic               cnt_en,
  input  logic               chain_en,
  input  logic [TOTAL_W-1:0] din,
  output logic [TOTAL_W-1:0] q,
  output logic               carry_out
);
  logic               clr_sync_n;
  logic [NSTAGES:0]   link;

  cnt_clr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .clear_n    (clear_n),
    .clr_sync_n (clr_sync_n)
  );

  assign link[0] = chain_en;

  for (genvar g = 0; g < NSTAGES; g++) begin : g_stage
    cnt_stage #(.W(STAGE_W)) u_stage (
      .clk    (clk),
      .clr_n  (clr_sync_n),
      .load_n (load_n),
      .en_p   (cnt_en),
      .en_t   (link[g]),
      .d      (din[g*STAGE_W +: STAGE_W]),
      .q      (q[g*STAGE_W +: STAGE_W]),
      .tc     (link[g+1])
    );
  end

  assign carry_out = link[NSTAGES];
endmodule

// File: rtl/cnt_chain_chk.sv
module cnt_chain_chk #(
  parameter int TOTAL_W = 8
) (
  input logic               clk,
  input logic               clear_n,
  input logic               load_n,
  input logic               cnt_en,
  input logic               chain_en,
  input logic [TOTAL_W-1:0] din,
  input logic [TOTAL_W-1:0] q,
  input logic               carry_out,
  input logic               clr_sync_n
);
  // R1: clear holds the counter at zero.
  always @(posedge clk) begin
    if (!clear_n) begin
      assert_clear_zero_R1: assert (q == '0 && !carry_out);
    end
  end

  assert_load_R3: assert property (@(posedge clk) disable iff (!clr_sync_n)
    !load_n |=> q == $past(din));

  assert_count_R4: assert property (@(posedge clk) disable iff (!clr_sync_n)
    (load_n && cnt_en && chain_en) |=> q == TOTAL_W'($past(q) + 1'b1));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!clr_sync_n)
    (load_n && !(cnt_en && chain_en)) |=> $stable(q));

  assert_carry_full_R8: assert property (@(posedge clk) disable iff (!clr_sync_n)
    carry_out |-> (&q) && chain_en);

  assert_carry_gate_R8: assert property (@(posedge clk) disable iff (!clr_sync_n)
    ((&q) && chain_en) |-> carry_out);
endmodule

bind cnt_chain cnt_chain_chk #(.TOTAL_W(TOTAL_W)) u_chk (
  .clk        (clk),
  .clear_n    (clear_n),
  .load_n     (load_n),
  .cnt_en     (cnt_en),
  .chain_en   (chain_en),
  .din        (din),
  .q          (q),
  .carry_out  (carry_out),
  .clr_sync_n (clr_sync_n)
);

// File: tb/sim_cnt_chain.sv
module sim_cnt_chain;
  localparam int W = 8;
  localparam int NV = 12;

  logic         clk = 1'b0;
  logic         clear_n = 1'b0;
  logic         load_n = 1'b1;
  logic         cnt_en = 1'b0;
  logic         chain_en = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] q;
  logic         carry_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cnt_chain u0 (
    .clk       (clk),
    .clear_n   (clear_n),
    .load_n    (load_n),
    .cnt_en    (cnt_en),
    .chain_en  (chain_en),
    .din       (din),
    .q         (q),
    .carry_out (carry_out)
  );

  // {load_n, cnt_en, chain_en, din, expected q, expected carry}; starts from q=0x5A
  localparam logic [19:0] VEC [NV] = '{
    {3'b111, 8'h00, 8'h5B, 1'b0},  // R4 count
    {3'b101, 8'h00, 8'h5B, 1'b0},  // R5 hold, cnt_en low
    {3'b110, 8'h00, 8'h5B, 1'b0},  // R5 hold, chain_en low
    {3'b000, 8'h0E, 8'h0E, 1'b0},  // R3 load with enables low
    {3'b111, 8'h00, 8'h0F, 1'b0},  // R4 count
    {3'b111, 8'h00, 8'h10, 1'b0},  // R7 carry into upper stage
    {3'b011, 8'hFE, 8'hFE, 1'b0},  // R3 load beats count
    {3'b111, 8'h00, 8'hFF, 1'b1},  // R8 carry at all ones
    {3'b111, 8'h00, 8'h00, 1'b0},  // R6 wrap
    {3'b000, 8'h0F, 8'h0F, 1'b0},  // R3 load
    {3'b110, 8'h00, 8'h0F, 1'b0},  // R7 no step with chain_en low
    {3'b111, 8'h00, 8'h10, 1'b0}   // R7 step
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #20;
    check("R1 reset q", q, 8'h00);
    check("R1 reset carry", W'(carry_out), 8'h00);

    // Release clear with a load pending.
    @(negedge clk);
    clear_n = 1'b1; load_n = 1'b0; din = 8'h5A; cnt_en = 1'b1; chain_en = 1'b1;
    @(negedge clk); check("R2 edge1 held", q, 8'h00);
    @(negedge clk); check("R2 edge2 held", q, 8'h00);
    @(negedge clk); check("R3 first load", q, 8'h5A);

    for (int i = 0; i < NV; i++) begin
      {load_n, cnt_en, chain_en, din} = VEC[i][19:9];
      @(negedge clk);
      check($sformatf("R3-7 vector %0d q", i), q, VEC[i][8:1]);
      check($sformatf("R8 vector %0d carry", i), W'(carry_out), W'(VEC[i][0]));
    end

    // R8: carry follows chain_en with no clock edge.
    load_n = 1'b0; din = 8'hFF;
    @(negedge clk);
    load_n = 1'b1; cnt_en = 1'b0; chain_en = 1'b1;
    #1 check("R8 carry high", W'(carry_out), 8'h01);
    chain_en = 1'b0;
    #1 check("R8 carry follows enable low", W'(carry_out), 8'h00);
    chain_en = 1'b1;
    #1 check("R8 carry follows enable high", W'(carry_out), 8'h01);

    // R1: clear mid-cycle, immediate effect, beats a pending load.
    clear_n = 1'b0;
    #1 check("R1 async clear q", q, 8'h00);
    check("R1 async clear carry", W'(carry_out), 8'h00);
    load_n = 1'b0; din = 8'h33;
    @(negedge clk); check("R1 clear beats load", q, 8'h00);

    // R2: release again, two dead edges then load.
    clear_n = 1'b1;
    @(negedge clk); check("R2 second release edge1", q, 8'h00);
    @(negedge clk); check("R2 second release edge2", q, 8'h00);
    @(negedge clk); check("R2 third edge loads", q, 8'h33);

    // R4/R6 short count run from 0xFD.
    din = 8'hFD;
    @(negedge clk);
    load_n = 1'b1; cnt_en = 1'b1; chain_en = 1'b1;
    @(negedge clk); check("R4 FD->FE", q, 8'hFE);
    @(negedge clk); check("R4 FE->FF", q, 8'hFF);
    @(negedge clk); check("R6 FF->00", q, 8'h00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule